// File: doc/BRIEF.md
# Rotating-Priority DMA Channel Arbiter

This block chooses which of four DMA channels may run its transfer next. Each channel raises a request on its own input bit, as a one-cycle pulse or a held level. The arbiter remembers every request in a pending bit. When no transfer is running, it grants one pending channel on a one-hot output. That grant stays fixed until the transfer-done strobe arrives, and no later request can take it away.

Channel ranking is a cyclic order described by its head, which is the index of the highest-ranked channel. The head starts at 0, giving the ranking 0, 1, 2, 3. Each time a transfer completes, the head moves to the index just after the served channel. The served channel therefore drops to the bottom of the ranking, and the others keep their cyclic sequence. The head is brought out so that other logic can see the current ranking.

Top module: `dma_rr_arbiter`

## Requirements
- R1: While reset is held and after it is released, `grant_o` is 0, `busy_o` is 0 and `top_ch_o` is 0.
- R2: Suppose `req_i[i]` is sampled high at a clock edge while the arbiter is idle and nothing else is pending. Then `grant_o` equals the one-hot value with bit i set (value 1<<i) after the next edge, not after the sampling edge.
- R3: When the arbiter is idle and several channels are pending, it grants the first pending channel found by scanning from `top_ch_o` upward and wrapping past 3 to 0.
- R4: At most one bit of `grant_o` is high, and `busy_o` is high exactly when some bit of `grant_o` is high.
- R5: While `busy_o` is high and `done_i` is low, `grant_o` keeps its value whatever `req_i` does.
- R6: If `done_i` is sampled high while `busy_o` is high, then after that edge `grant_o` and `busy_o` are 0. Also, `top_ch_o` becomes the served channel index plus one, modulo 4.
- R7: `top_ch_o` changes only at a completion as in R6. Issuing a grant leaves it unchanged.
- R8: A channel's pending bit clears at the edge that grants it. A request from that channel sampled at that same edge is absorbed. A request from that channel sampled at a later edge while it is still busy is kept, and it is served later.
- R9: After the completion edge, the next grant is issued at the following edge if any channel is pending, using the updated order. Otherwise the arbiter stays idle with `grant_o` equal to 0.
- R10: A `done_i` pulse sampled while `busy_o` is low changes nothing: `top_ch_o` and `grant_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NUM_CH | Per-channel transfer request, pulse or level |
| done_i | input | 1 | Strobe marking the end of the granted transfer |
| grant_o | output | NUM_CH | One-hot grant, registered |
| busy_o | output | 1 | A granted transfer is in progress, registered |
| top_ch_o | output | IDX_W | Index of the highest-ranked channel |

## Verification
The hardest case to reach from the ports is a collision between a request and the grant of the same channel. The request may land on the very edge that issues the grant, where it must be absorbed. Or it may come on a later edge of that same transfer, where it must be kept. Directed sequences place a request from the granted channel on each of these two edges. They also replay a three-transfer rotation in which waiting channels overtake each other. Seeded random traffic then mixes dense requests with done strobes that often arrive while the arbiter is idle. Every cycle is compared against a cycle-accurate reference model inside the bench.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_XFER = 1'b1
  } arb_state_e;

endpackage

// File: rtl/dmaarb_pending.sv
module dmaarb_pending #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] clr_mask_i,
  output logic [NUM_CH-1:0] pend_o
);

  logic [NUM_CH-1:0] pend_q;

  // a request that lands together with its own grant is absorbed
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q | req_i) & ~clr_mask_i;
    end
  end

  assign pend_o = pend_q;

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (|clr_mask_i) |=> ((pend_q & $past(clr_mask_i)) == '0)); // R8

endmodule

// File: rtl/dmaarb_ring.sv
module dmaarb_ring #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rotate_i,
  input  logic [IDX_W-1:0] served_i,
  output logic [IDX_W-1:0] head_o
);

  localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NUM_CH - 1);

  logic [IDX_W-1:0] head_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
    end else if (rotate_i) begin
      head_q <= (served_i == LAST_CH) ? '0 : served_i + 1'b1;
    end
  end

  assign head_o = head_q;

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rotate_i |=> $stable(head_q)); // R7

endmodule

// File: rtl/dmaarb_pick.sv
module dmaarb_pick #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [IDX_W-1:0]  head_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o
);

  logic [IDX_W:0]    slot_idx [NUM_CH];
  logic [NUM_CH-1:0] rot_pend;

  // slot g holds the channel ranked g-th below the head
  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [IDX_W:0] sum;
    assign sum         = {1'b0, head_i} + (IDX_W+1)'(g);
    assign slot_idx[g] = (sum >= (IDX_W+1)'(NUM_CH)) ? sum - (IDX_W+1)'(NUM_CH) : sum;
    assign rot_pend[g] = pend_i[slot_idx[g][IDX_W-1:0]];
  end

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (rot_pend[k]) begin
        valid_o = 1'b1;
        idx_o   = slot_idx[k][IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/dma_rr_arbiter.sv
module dma_rr_arbiter
  import dmaarb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              done_i,
  output logic [NUM_CH-1:0] grant_o,
  output logic              busy_o,
  output logic [IDX_W-1:0]  top_ch_o
);

  arb_state_e        state_q;
  logic [NUM_CH-1:0] grant_q;
  logic [IDX_W-1:0]  gidx_q;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] issue_mask;
  logic [IDX_W-1:0]  head;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_valid;
  logic              issue;
  logic              finish;

  dmaarb_pending #(.NUM_CH(NUM_CH)) u_pending (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .clr_mask_i (issue_mask),
    .pend_o     (pend)
  );

  dmaarb_pick #(.NUM_CH(NUM_CH)) u_pick (
    .pend_i  (pend),
    .head_i  (head),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  dmaarb_ring #(.NUM_CH(NUM_CH)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .rotate_i (finish),
    .served_i (gidx_q),
    .head_o   (head)
  );

  assign issue      = (state_q == ARB_IDLE) && pick_valid;
  assign finish     = (state_q == ARB_XFER) && done_i;
  assign issue_mask = issue ? (NUM_CH'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
      gidx_q  <= '0;
    end else if (issue) begin
      state_q <= ARB_XFER;
      grant_q <= issue_mask;
      gidx_q  <= pick_idx;
    end else if (finish) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
    end
  end

  assign grant_o  = grant_q;
  assign busy_o   = (state_q == ARB_XFER);
  assign top_ch_o = head;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o)); // R4
  AST_BUSY_GRANT: assert property (@(posedge clk) disable iff (rst)
    busy_o == (grant_o != '0)); // R4
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_i) |=> $stable(grant_o)); // R5
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && done_i) |=> (!busy_o && grant_o == '0)); // R6
  AST_IDLE_SERVES: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && pend != '0) |=> busy_o); // R9
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && done_i) |=> $stable(top_ch_o)); // R10

endmodule

// File: tb/dma_rr_arbiter_bench.sv
module dma_rr_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] req;
  logic       done;
  logic [3:0] grant_o;
  logic       busy_o;
  logic [1:0] top_ch_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0] m_pend;
  int         m_head;
  bit         m_busy;
  int         m_gidx;

  always #5 clk = ~clk;

  dma_rr_arbiter u_dma_rr_arbiter (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req),
    .done_i   (done),
    .grant_o  (grant_o),
    .busy_o   (busy_o),
    .top_ch_o (top_ch_o)
  );

  function automatic int first_pending(logic [3:0] p, int h);
    for (int k = 0; k < 4; k++) begin
      if (p[(h + k) % 4]) return (h + k) % 4;
    end
    return -1;
  endfunction

  task automatic model_edge(logic [3:0] r, logic d);
    int p;
    if (m_busy) begin
      if (d) begin
        m_busy = 1'b0;
        m_head = (m_gidx + 1) % 4;
      end
      m_pend = m_pend | r;
    end else begin
      p = first_pending(m_pend, m_head);
      if (p >= 0) begin
        m_busy = 1'b1;
        m_gidx = p;
        m_pend = (m_pend | r) & ~(4'(1) << p);
      end else begin
        m_pend = m_pend | r;
      end
    end
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic [3:0] r, logic d);
    logic [3:0] eg;
    req  = r;
    done = d;
    @(posedge clk);
    model_edge(r, d);
    @(negedge clk);
    eg = m_busy ? (4'(1) << m_gidx) : 4'h0;
    check("R3", "grant", 32'(grant_o), 32'(eg));
    check("R4", "busy", 32'(busy_o), 32'(m_busy));
    check("R6", "top", 32'(top_ch_o), 32'(m_head));
  endtask

  initial begin
    rst  = 1'b1;
    req  = '0;
    done = 1'b0;
    m_pend = '0; m_head = 0; m_busy = 1'b0; m_gidx = 0;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "grant", 32'(grant_o), 0);
    check("R1", "busy", 32'(busy_o), 0);
    check("R1", "top", 32'(top_ch_o), 0);
    rst = 1'b0;

    // rotation walk: 0 and 3 together, 1 arrives during 0's transfer
    cyc(4'b1001, 1'b0); check("R2", "grant early", 32'(grant_o), 0);
    cyc(4'b0000, 1'b0); check("R2", "grant", 32'(grant_o), 32'h1);
    check("R7", "top after grant", 32'(top_ch_o), 0);
    cyc(4'b0010, 1'b0); check("R5", "grant held", 32'(grant_o), 32'h1);
    cyc(4'b0000, 1'b1); check("R6", "top after ch0", 32'(top_ch_o), 1);
    check("R6", "busy after done", 32'(busy_o), 0);
    cyc(4'b0000, 1'b0); check("R9", "grant ch1", 32'(grant_o), 32'h2);
    cyc(4'b0000, 1'b1); check("R6", "top after ch1", 32'(top_ch_o), 2);
    cyc(4'b0000, 1'b0); check("R3", "grant ch3", 32'(grant_o), 32'h8);
    cyc(4'b0000, 1'b1); check("R6", "top after ch3", 32'(top_ch_o), 0);
    cyc(4'b0000, 1'b0); check("R9", "idle no grant", 32'(grant_o), 0);
    // done while idle
    cyc(4'b0000, 1'b1); check("R10", "top kept", 32'(top_ch_o), 0);
    check("R10", "grant kept", 32'(grant_o), 0);
    // re-request during own transfer is kept
    cyc(4'b0100, 1'b0);
    cyc(4'b0000, 1'b0); check("R2", "grant ch2", 32'(grant_o), 32'h4);
    cyc(4'b0100, 1'b0);
    cyc(4'b0000, 1'b1); check("R6", "top after ch2", 32'(top_ch_o), 3);
    cyc(4'b0000, 1'b0); check("R8", "relatched ch2", 32'(grant_o), 32'h4);
    cyc(4'b0000, 1'b1);
    // request on the grant edge of the same channel is absorbed
    cyc(4'b0010, 1'b0);
    cyc(4'b0010, 1'b0); check("R8", "grant ch1", 32'(grant_o), 32'h2);
    cyc(4'b0000, 1'b1);
    cyc(4'b0000, 1'b0); check("R8", "absorbed", 32'(busy_o), 0);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = ($urandom % 3 == 0) ? 4'($urandom % 16) : 4'h0;
      cyc(r, ($urandom % 4) == 0);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule